// File: doc/BRIEF.md
# ADC Channel Sequencer Controller

This block is the digital control section in front of an eight-input analog converter. A host drives a parallel bus with a write strobe and a chip select. Each write lands either in a 12-bit configuration word or in an 8-bit channel-enable mask. The mask can only be reached when the configuration write just before it asked for that.

A conversion-start strobe comes in from the host. On each falling edge of that strobe, the block issues a one-cycle conversion request. It also places the address of the channel to convert on its outputs. With sequencing enabled, successive starts walk the enabled channels upward and wrap. In the paired input modes the walk goes by channel pair, and only the even, normal-polarity member is ever addressed. With sequencing disabled, the address is taken straight from the configuration word.

All inputs are sampled on the block clock, and strobe edges are found by comparing each sample with the one before it. The full configuration word is passed on to the analog front end.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the configuration word is 0, the channel address is 0, the input mode is 0, no request is pending and sequencing is off.
- R2: A rising edge of wr_n sampled while cs_n is low is a host write. A write with cs_n high leaves cfg_word and every other output unchanged.
- R3: Configuration fields: channel address in bits 2..0, input mode in bits 4..3, arm bit in bit 5 and sequence bit in bit 6. Input mode codes: 0 single-ended, 1 seven inputs against a common, 2 fully differential pairs, 3 pseudo-differential pairs. in_mode shows bits 4..3.
- R4: Each falling edge of cnv_n raises conv_req for exactly one cycle. conv_req rises in the cycle after the first sample in which cnv_n is low.
- R5: A write goes to the channel mask only when the configuration write just before it had sequence=0 and arm=1. Such a write leaves cfg_word unchanged, loads bus bits 7..0 (bit n enables channel n) and starts sequencing. The write after it goes to the configuration word again.
- R6: In input modes 0 and 1, each conversion start selects the next enabled channel in ascending order. The first start after sequencing begins takes the lowest enabled channel, and the walk wraps from the highest enabled channel to the lowest.
- R7: In input modes 2 and 3, pair k (channels 2k and 2k+1) takes part only when both mask bits are set. The address given is 2k, never an odd channel.
- R8: A configuration write with sequence=1 and arm=0 keeps sequencing, the mask and the position. A write with sequence=0 stops sequencing. With arm=1, sequencing stays off until the mask write.
- R9: A configuration write with sequence=1 and arm=1 starts sequencing over channels 0 up to its address field, walked upward from 0 and wrapping.
- R10: If the effective mask is empty while sequencing, conversion starts still raise conv_req and the channel address holds. When sequencing starts, the address held is the address field of the configuration word.
- R11: With sequencing off, ch_addr equals the address field of cfg_word. A conversion start only raises conv_req and leaves ch_addr unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_data | input | 12 | Host write data |
| wr_n | input | 1 | Active-low write strobe; the data is taken on its rising edge |
| cs_n | input | 1 | Active-low chip select |
| cnv_n | input | 1 | Active-low conversion-start strobe |
| ch_addr | output | 3 | Channel address for the current or next conversion |
| in_mode | output | 2 | Input configuration code |
| conv_req | output | 1 | One-cycle conversion request |
| cfg_word | output | 12 | Stored configuration word |

## Verification
The properties assume that a host write and a conversion-start edge never fall in the same clock cycle. They also assume that the mask and the mode do not change in the cycle a conversion start is taken. The stimulus keeps to this: every host access runs to completion before a conversion strobe is lowered. Each strobe is held for at least one full clock in each level, so every edge is seen on a clock sample.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CTRL_W    = 12;
    localparam int NUM_CH    = 8;
    localparam int F_ADDR_LO = 0;
    localparam int F_MODE_LO = 3;
    localparam int F_ARM     = 5;
    localparam int F_SEQ     = 6;

    // Sequencer command, coded as {sequence bit, arm bit}
    typedef enum logic [1:0] {
        CMD_OFF  = 2'b00,
        CMD_ARM  = 2'b01,
        CMD_KEEP = 2'b10,
        CMD_RAMP = 2'b11
    } seq_cmd_e;

    // Input configuration; the upper bit means paired operation
    typedef enum logic [1:0] {
        IN_SINGLE  = 2'b00,
        IN_COMMON  = 2'b01,
        IN_DIFF    = 2'b10,
        IN_PSEUDO  = 2'b11
    } in_mode_e;

endpackage

// File: rtl/adc_seq_edge.sv
module adc_seq_edge #(
    parameter bit RISE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic hit
);

    logic prev_d, prev_q;

    always_comb begin
        prev_d = sig;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= prev_d;
    end

    generate
        if (RISE) begin : g_rise
            assign hit = !prev_q && sig;
        end else begin : g_fall
            assign hit = prev_q && !sig;
        end
    endgenerate

endmodule

// File: rtl/adc_seq_mask.sv
module adc_seq_mask #(
    parameter int NCH = 8
) (
    input  logic [NCH-1:0] raw,
    input  logic           paired,
    output logic [NCH-1:0] eff
);

    localparam int NPAIR = NCH / 2;

    generate
        for (genvar k = 0; k < NPAIR; k++) begin : g_pair
            // Pair modes keep only the even member, and only with both bits set
            assign eff[2*k]   = paired ? (raw[2*k] & raw[2*k+1]) : raw[2*k];
            assign eff[2*k+1] = paired ? 1'b0 : raw[2*k+1];
        end
    endgenerate

endmodule

// File: rtl/adc_seq_pick.sv
module adc_seq_pick #(
    parameter int NCH = 8,
    parameter int AW  = $clog2(NCH)
) (
    input  logic [NCH-1:0] eff,
    input  logic [AW-1:0]  cur,
    input  logic           from_start,
    output logic [AW-1:0]  nxt,
    output logic           found
);

    always_comb begin
        int base;
        base  = from_start ? 0 : (int'(cur) + 1);
        nxt   = cur;
        found = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            int idx;
            idx = (base + i) % NCH;
            if (!found && eff[idx]) begin
                found = 1'b1;
                nxt   = AW'(idx);
            end
        end
    end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
    parameter int DATA_W = adc_seq_pkg::CTRL_W,
    parameter int NCH    = adc_seq_pkg::NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              wr_n,
    input  logic              cs_n,
    input  logic              cnv_n,
    output logic [$clog2(NCH)-1:0] ch_addr,
    output logic [1:0]        in_mode,
    output logic              conv_req,
    output logic [DATA_W-1:0] cfg_word
);
    import adc_seq_pkg::*;

    localparam int AW = $clog2(NCH);

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [NCH-1:0]    mask;
        logic              armed;
        logic              seq_on;
        logic              first;
        logic [AW-1:0]     ch;
        logic              req;
    } state_t;

    state_t s_d, s_q;

    logic          wr_rise, cnv_fall, wr_ev;
    logic [NCH-1:0] eff_mask;
    logic [AW-1:0] pick_ch;
    logic          pick_ok;

    adc_seq_edge #(.RISE(1'b1)) u_wr_edge (
        .clk(clk), .rst_n(rst_n), .sig(wr_n), .hit(wr_rise)
    );

    adc_seq_edge #(.RISE(1'b0)) u_cnv_edge (
        .clk(clk), .rst_n(rst_n), .sig(cnv_n), .hit(cnv_fall)
    );

    assign wr_ev = wr_rise && !cs_n;

    adc_seq_mask #(.NCH(NCH)) u_mask (
        .raw    (s_q.mask),
        .paired (s_q.ctrl[F_MODE_LO+1]),
        .eff    (eff_mask)
    );

    adc_seq_pick #(.NCH(NCH), .AW(AW)) u_pick (
        .eff        (eff_mask),
        .cur        (s_q.ch),
        .from_start (s_q.first),
        .nxt        (pick_ch),
        .found      (pick_ok)
    );

    always_comb begin
        seq_cmd_e      cmd;
        logic [AW-1:0] new_addr;
        logic [NCH-1:0] ramp;

        cmd      = seq_cmd_e'({bus_data[F_SEQ], bus_data[F_ARM]});
        new_addr = bus_data[F_ADDR_LO +: AW];
        for (int i = 0; i < NCH; i++) begin
            ramp[i] = (i <= int'(new_addr));
        end

        s_d     = s_q;
        s_d.req = 1'b0;

        if (cnv_fall) begin
            s_d.req = 1'b1;
            if (s_q.seq_on && pick_ok) begin
                s_d.ch    = pick_ch;
                s_d.first = 1'b0;
            end
        end

        if (wr_ev) begin
            if (s_q.armed) begin
                s_d.mask   = bus_data[NCH-1:0];
                s_d.armed  = 1'b0;
                s_d.seq_on = 1'b1;
                s_d.first  = 1'b1;
                s_d.ch     = s_q.ctrl[F_ADDR_LO +: AW];
            end else begin
                s_d.ctrl  = bus_data;
                s_d.armed = (cmd == CMD_ARM);
                case (cmd)
                    CMD_OFF, CMD_ARM: s_d.seq_on = 1'b0;
                    CMD_KEEP:         s_d.seq_on = s_q.seq_on;
                    CMD_RAMP: begin
                        s_d.mask   = ramp;
                        s_d.seq_on = 1'b1;
                        s_d.first  = 1'b1;
                        s_d.ch     = new_addr;
                    end
                    default:          s_d.seq_on = 1'b0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ch_addr  = s_q.seq_on ? s_q.ch : s_q.ctrl[F_ADDR_LO +: AW];
    assign in_mode  = s_q.ctrl[F_MODE_LO +: 2];
    assign conv_req = s_q.req;
    assign cfg_word = s_q.ctrl;

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
    parameter int NCH = 8,
    parameter int AW  = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cnv_n,
    input logic           conv_req,
    input logic [AW-1:0]  ch_addr,
    input logic           seq_on,
    input logic [NCH-1:0] eff_mask,
    input logic           wr_ev
);

    // R4: a sampled fall of the start strobe yields a request next cycle
    p_req_after_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cnv_n) |=> conv_req);

    // R4: the request lasts a single cycle
    p_req_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |=> !conv_req);

    // R6 and R7: a sequenced request addresses an enabled channel
    p_pick_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && seq_on && (eff_mask != '0) && $stable(eff_mask)) |-> eff_mask[ch_addr]);

    // R11: the address moves only with a request or right after a host write
    p_addr_moves_on_event_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ch_addr) |-> (conv_req || $past(wr_ev)));

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.NCH(NCH), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnv_n    (cnv_n),
    .conv_req (conv_req),
    .ch_addr  (ch_addr),
    .seq_on   (s_q.seq_on),
    .eff_mask (eff_mask),
    .wr_ev    (wr_ev)
);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_data = '0;
    logic        wr_n = 1'b1;
    logic        cs_n = 1'b1;
    logic        cnv_n = 1'b1;
    logic [2:0]  ch_addr;
    logic [1:0]  in_mode;
    logic        conv_req;
    logic [11:0] cfg_word;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    adc_seq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .wr_n(wr_n),
        .cs_n(cs_n), .cnv_n(cnv_n), .ch_addr(ch_addr), .in_mode(in_mode),
        .conv_req(conv_req), .cfg_word(cfg_word)
    );

    task automatic check(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic host_write(input logic [11:0] d, input bit sel = 1'b1);
        @(negedge clk);
        cs_n = !sel; bus_data = d; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1;
    endtask

    task automatic convert(input string tag, input int exp_ch);
        @(negedge clk);
        cnv_n = 1'b0;
        @(negedge clk);
        check({tag, " request"}, int'(conv_req), 1);
        check({tag, " channel"}, int'(ch_addr), exp_ch);
        cnv_n = 1'b1;
        @(negedge clk);
        check({tag, " one-cycle request"}, int'(conv_req), 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 cfg_word", int'(cfg_word), 0);
        check("R1 ch_addr", int'(ch_addr), 0);
        check("R1 in_mode", int'(in_mode), 0);
        check("R1 conv_req", int'(conv_req), 0);
    endtask

    task automatic t_direct;
        host_write(12'h005);
        check("R2 cfg_word", int'(cfg_word), 5);
        check("R11 direct address", int'(ch_addr), 5);
        convert("R11 R4 direct start", 5);
        host_write(12'h00B);
        check("R3 address field", int'(ch_addr), 3);
        check("R3 mode field", int'(in_mode), 1);
    endtask

    task automatic t_ignore_cs;
        host_write(12'h7FF, 1'b0);
        check("R2 deselected write cfg", int'(cfg_word), 12'h00B);
        check("R2 deselected write addr", int'(ch_addr), 3);
    endtask

    task automatic t_single_seq;
        host_write(12'h020);
        check("R5 arm write stored", int'(cfg_word), 12'h020);
        host_write(12'h025);
        check("R5 mask write keeps cfg", int'(cfg_word), 12'h020);
        convert("R6 first lowest", 0);
        convert("R6 ascending a", 2);
        convert("R6 ascending b", 5);
        convert("R6 wrap", 0);
        convert("R6 after wrap", 2);
    endtask

    task automatic t_keep;
        host_write(12'h040);
        check("R5 next write to cfg", int'(cfg_word), 12'h040);
        convert("R8 keep position", 5);
        convert("R8 keep wrap", 0);
    endtask

    task automatic t_pair_diff;
        host_write(12'h030);
        host_write(12'h0CB);
        check("R7 diff mode", int'(in_mode), 2);
        convert("R7 diff pair 0", 0);
        convert("R7 diff pair 3", 6);
        convert("R7 diff wrap", 0);
    endtask

    task automatic t_pair_pseudo;
        host_write(12'h038);
        host_write(12'h03C);
        check("R7 pseudo mode", int'(in_mode), 3);
        convert("R7 pseudo pair 1", 2);
        convert("R7 pseudo pair 2", 4);
        convert("R7 pseudo wrap", 2);
    endtask

    task automatic t_empty;
        host_write(12'h023);
        host_write(12'h000);
        check("R10 held address", int'(ch_addr), 3);
        convert("R10 empty start a", 3);
        convert("R10 empty start b", 3);
    endtask

    task automatic t_ramp;
        host_write(12'h062);
        convert("R9 ramp 0", 0);
        convert("R9 ramp 1", 1);
        convert("R9 ramp 2", 2);
        convert("R9 ramp wrap", 0);
    endtask

    task automatic t_stop;
        host_write(12'h004);
        check("R8 stop address", int'(ch_addr), 4);
        convert("R11 stopped start", 4);
        host_write(12'h062);
        convert("R9 ramp restart", 0);
        host_write(12'h021);
        check("R8 arm stops", int'(ch_addr), 1);
        convert("R8 armed start direct", 1);
        host_write(12'h0C0);
        convert("R6 new mask a", 6);
        convert("R6 new mask b", 7);
        convert("R6 new mask wrap", 6);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_direct();
        t_ignore_cs();
        t_single_seq();
        t_keep();
        t_pair_diff();
        t_pair_pseudo();
        t_empty();
        t_ramp();
        t_stop();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got 0 expected 1 (run completion)");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule